// File: doc/BRIEF.md
# Bus Cycle Termination Classifier

This block watches how an asynchronous bus cycle ends and tells the bus master which kind of ending occurred. The termination inputs are a two-bit active-low transfer acknowledge, an active-low bus error and an active-low halt. They are captured on the falling edge of the processor clock. External logic changes them on the rising edge, so two signals that assert together appear in the same falling-edge sample. The classification and all control run on the rising edge.

A cycle-start pulse arms the classifier. The block then follows the order in which acknowledge, bus error and halt arrive. After the first sample that shows acknowledge, it allows a configurable number of further falling-edge samples (one by default) for a late bus error or a late bus error with halt. When the cycle can complete, it commits one of four results and raises a done strobe for a single clock. It then ignores its inputs until the next cycle start. The bus master uses the result to decide whether to carry on, halt, take a bus-error exception or re-run the cycle. This block does not perform any of those actions.

Top module: `termClassifier`

## Requirements
- R1: While the synchronous active-high reset is applied, and on the first rising edge after it, `termDone` is 0 and `termResult` is 2'b00. Inputs seen in the reset state do not start a classification.
- R2: Acknowledge counts as asserted when either bit of `ackN` is low. Only values captured at a falling edge of `clk` take part in classification.
- R3: With acknowledge asserted and bus error and halt negated in the acknowledge sample and in the one following sample, the result is 2'b00 (normal). `termDone` rises on the rising edge after that following sample.
- R4: When halt is sampled asserted together with or before acknowledge, and bus error stays negated, the result is 2'b01 (halt). It commits one sample after the acknowledge sample.
- R5: When bus error is sampled asserted with halt negated before any acknowledge has been sampled, the result is 2'b10 (bus error). It commits on the rising edge right after that sample.
- R6: When bus error alone arrives in the sample after the acknowledge sample, the result is 2'b10 (bus error) and it commits on that sample.
- R7: When bus error and halt are both sampled asserted, the result is 2'b11 (retry). This holds both in place of acknowledge and in the sample after it, and the result commits on that sample.
- R8: When several conditions appear in the same sample, retry (11) wins over bus error (10), bus error wins over halt (01), and halt wins over normal (00).
- R9: A halt that first appears in the sample after acknowledge, with bus error negated, does not change the result, which stays 2'b00.
- R10: `termDone` is high for exactly one clock per classified cycle. `termResult` keeps its value until the next commit.
- R11: Between a commit (or reset) and the next `cycleStart`, the inputs have no effect: `termDone` stays 0 and `termResult` is unchanged.
- R12: While no acknowledge, bus error or halt-with-bus-error has been sampled, the classifier keeps waiting indefinitely without raising `termDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock. Inputs are captured on its falling edge; the state changes on its rising edge. |
| rst | input | 1 | Synchronous active-high reset. |
| cycleStart | input | 1 | Arms the classifier for a new bus cycle. |
| ackN | input | 2 | Active-low transfer acknowledge. Either bit low counts as asserted. |
| berrN | input | 1 | Active-low bus error. |
| haltN | input | 1 | Active-low halt. |
| termDone | output | 1 | Single-clock strobe that marks the commit of a result. |
| termResult | output | 2 | 00 normal, 01 halt, 10 bus error, 11 retry. Held between commits. |

## Verification
The hardest situations to reach are the late arrivals. A bus error, or a bus error with halt, must land exactly in the one sample that follows the acknowledge sample. A halt arriving in that same sample must be shown to have no effect. The stimulus drives the pins just after a rising edge, so each value is captured by the next falling edge. Each scenario then steps the acknowledge sample and the grace sample one clock apart, and checks that `termDone` is still low after the first step and that the result commits on the second. Reset in the middle of a cycle and stimulus while idle are driven the same way, to show that nothing is committed.

// File: rtl/termClassifierPkg.sv
`timescale 1ns/1ps
package termClassifierPkg;

  typedef enum logic [1:0] {
    TERM_NORMAL = 2'b00,
    TERM_HALT   = 2'b01,
    TERM_BUSERR = 2'b10,
    TERM_RETRY  = 2'b11
  } termKind_e;

  // One falling-edge snapshot of the termination inputs, active high.
  typedef struct packed {
    logic ack;
    logic berr;
    logic halt;
  } termSample_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic      clearFlag;
    logic      setFlag;
    logic      commit;
    termKind_e sel;
  } ctlStrobe_t;

endpackage

// File: rtl/termSampler.sv
`timescale 1ns/1ps
module termSampler
  import termClassifierPkg::*;
#(
  parameter int ACK_WIDTH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ACK_WIDTH-1:0] ackN,
  input  logic                 berrN,
  input  logic                 haltN,
  output termSample_t          sampleOut
);

  // Capture on the falling edge; external logic changes on the rising edge.
  always_ff @(negedge clk) begin
    if (rst) begin
      sampleOut <= '0;
    end else begin
      sampleOut.ack  <= ~(&ackN);
      sampleOut.berr <= ~berrN;
      sampleOut.halt <= ~haltN;
    end
  end

endmodule

// File: rtl/termControl.sv
`timescale 1ns/1ps
module termControl
  import termClassifierPkg::*;
#(
  parameter int GRACE_SAMPLES = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cycleStart,
  input  termSample_t sampleIn,
  input  logic        haltFlag,
  output ctlStrobe_t  strobe,
  output logic        busy
);

  localparam int CNT_W = (GRACE_SAMPLES > 1) ? $clog2(GRACE_SAMPLES) : 1;
  localparam logic [CNT_W-1:0] GRACE_LAST = CNT_W'(GRACE_SAMPLES - 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WAIT  = 2'b01,
    ST_GRACE = 2'b10
  } ctlState_e;

  ctlState_e        state, stateNext;
  logic [CNT_W-1:0] graceCnt, graceCntNext;

  always_comb begin
    stateNext    = state;
    graceCntNext = graceCnt;
    strobe       = '0;
    strobe.sel   = TERM_NORMAL;
    unique case (state)
      ST_IDLE: begin
        if (cycleStart) begin
          strobe.clearFlag = 1'b1;
          stateNext        = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (sampleIn.berr && sampleIn.halt) begin
          strobe.commit = 1'b1;
          strobe.sel    = TERM_RETRY;
          stateNext     = ST_IDLE;
        end else if (sampleIn.berr) begin
          strobe.commit = 1'b1;
          strobe.sel    = TERM_BUSERR;
          stateNext     = ST_IDLE;
        end else begin
          strobe.setFlag = sampleIn.halt;
          if (sampleIn.ack) begin
            graceCntNext = '0;
            stateNext    = ST_GRACE;
          end
        end
      end
      ST_GRACE: begin
        if (sampleIn.berr && sampleIn.halt) begin
          strobe.commit = 1'b1;
          strobe.sel    = TERM_RETRY;
          stateNext     = ST_IDLE;
        end else if (sampleIn.berr) begin
          strobe.commit = 1'b1;
          strobe.sel    = TERM_BUSERR;
          stateNext     = ST_IDLE;
        end else if (graceCnt == GRACE_LAST) begin
          strobe.commit = 1'b1;
          strobe.sel    = haltFlag ? TERM_HALT : TERM_NORMAL;
          stateNext     = ST_IDLE;
        end else begin
          graceCntNext = graceCnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      graceCnt <= '0;
    end else begin
      state    <= stateNext;
      graceCnt <= graceCntNext;
    end
  end

  assign busy = (state != ST_IDLE);

  // R11: an idle classifier stays idle until armed.
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !cycleStart) |=> (state == ST_IDLE));

  // R6: the grace window never falls back to waiting for acknowledge.
  a_r6_grace_forward: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GRACE) |=> (state != ST_WAIT));

  // R12: without any termination sample the wait continues.
  a_r12_keep_waiting: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !sampleIn.ack && !sampleIn.berr) |=> (state == ST_WAIT));

endmodule

// File: rtl/termDatapath.sv
`timescale 1ns/1ps
module termDatapath
  import termClassifierPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t strobe,
  output logic       haltFlag,
  output logic       doneOut,
  output termKind_e  resultOut
);

  always_ff @(posedge clk) begin
    if (rst) begin
      haltFlag  <= 1'b0;
      doneOut   <= 1'b0;
      resultOut <= TERM_NORMAL;
    end else begin
      if (strobe.clearFlag) begin
        haltFlag <= 1'b0;
      end else if (strobe.setFlag) begin
        haltFlag <= 1'b1;
      end
      doneOut <= strobe.commit;
      if (strobe.commit) begin
        resultOut <= strobe.sel;
      end
    end
  end

  // R10: done lasts a single clock.
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut);

  // R10: result is held between commits.
  a_r10_result_held: assert property (@(posedge clk) disable iff (rst)
    !strobe.commit |=> $stable(resultOut));

  // R7: a retry commit shows up as retry with done.
  a_r7_retry_lands: assert property (@(posedge clk) disable iff (rst)
    (strobe.commit && strobe.sel == TERM_RETRY) |=> (doneOut && resultOut == TERM_RETRY));

endmodule

// File: rtl/termClassifier.sv
`timescale 1ns/1ps
module termClassifier
  import termClassifierPkg::*;
#(
  parameter int ACK_WIDTH     = 2,
  parameter int GRACE_SAMPLES = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cycleStart,
  input  logic [ACK_WIDTH-1:0] ackN,
  input  logic                 berrN,
  input  logic                 haltN,
  output logic                 termDone,
  output logic [1:0]           termResult
);

  termSample_t sampleNow;
  ctlStrobe_t  strobe;
  logic        haltFlag;
  logic        busy;
  termKind_e   resultKind;

  termSampler #(.ACK_WIDTH(ACK_WIDTH)) uSampler (
    .clk      (clk),
    .rst      (rst),
    .ackN     (ackN),
    .berrN    (berrN),
    .haltN    (haltN),
    .sampleOut(sampleNow)
  );

  termControl #(.GRACE_SAMPLES(GRACE_SAMPLES)) uControl (
    .clk       (clk),
    .rst       (rst),
    .cycleStart(cycleStart),
    .sampleIn  (sampleNow),
    .haltFlag  (haltFlag),
    .strobe    (strobe),
    .busy      (busy)
  );

  termDatapath uDatapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .haltFlag (haltFlag),
    .doneOut  (termDone),
    .resultOut(resultKind)
  );

  assign termResult = resultKind;

  // R11: done only follows a clock in which a cycle was armed.
  a_r11_done_needs_arm: assert property (@(posedge clk) disable iff (rst)
    (termDone && !$past(rst)) |-> $past(busy));

endmodule

// File: tb/tb_termClassifier.sv
`timescale 1ns/1ps
module tb_termClassifier;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cycleStart = 1'b0;
  logic [1:0] ackN = 2'b11;
  logic       berrN = 1'b1;
  logic       haltN = 1'b1;
  logic       termDone;
  logic [1:0] termResult;

  int total = 0;
  int bad   = 0;

  termClassifier dut (
    .clk       (clk),
    .rst       (rst),
    .cycleStart(cycleStart),
    .ackN      (ackN),
    .berrN     (berrN),
    .haltN     (haltN),
    .termDone  (termDone),
    .termResult(termResult)
  );

  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Drive the pins; ack, berr and halt given active high.
  task automatic drv(input logic [1:0] a, input logic b, input logic h);
    ackN  = a;
    berrN = ~b;
    haltN = ~h;
  endtask

  task automatic idleBus();
    drv(2'b11, 1'b0, 1'b0);
  endtask

  task automatic arm();
    cycleStart = 1'b1;
    step();
    cycleStart = 1'b0;
  endtask

  // Expect a commit now and a quiet done one clock later.
  task automatic expectCommit(input logic [1:0] res, input string tag);
    check({1'b0, termDone}, 2'b01, {tag, " done"});
    check(termResult, res, {tag, " result"});
    idleBus();
    step();
    check({1'b0, termDone}, 2'b00, "R10 done drops");
    check(termResult, res, "R10 result held");
  endtask

  task automatic tReset();
    check({1'b0, termDone}, 2'b00, "R1 done in reset");
    check(termResult, 2'b00, "R1 result in reset");
    drv(2'b00, 1'b1, 1'b1);
    step();
    rst = 1'b0;
    step();
    check({1'b0, termDone}, 2'b00, "R1 no commit after reset");
    idleBus();
  endtask

  task automatic tNormal(input logic [1:0] a, input string tag);
    arm();
    drv(a, 1'b0, 1'b0);
    step();
    check({1'b0, termDone}, 2'b00, {tag, " no early done"});
    step();
    expectCommit(2'b00, tag);
  endtask

  task automatic tHaltEarly();
    arm();
    drv(2'b11, 1'b0, 1'b1);
    step();
    drv(2'b00, 1'b0, 1'b1);
    step();
    check({1'b0, termDone}, 2'b00, "R4 wait grace");
    step();
    expectCommit(2'b01, "R4 halt before ack");
    arm();
    drv(2'b00, 1'b0, 1'b1);
    step();
    step();
    expectCommit(2'b01, "R4 halt with ack");
  endtask

  task automatic tBerrEarly();
    arm();
    drv(2'b11, 1'b1, 1'b0);
    step();
    expectCommit(2'b10, "R5 berr in lieu");
  endtask

  task automatic tBerrLate();
    arm();
    drv(2'b00, 1'b0, 1'b0);
    step();
    drv(2'b00, 1'b1, 1'b0);
    step();
    expectCommit(2'b10, "R6 late berr");
  endtask

  task automatic tRetry();
    arm();
    drv(2'b11, 1'b1, 1'b1);
    step();
    expectCommit(2'b11, "R7 retry in lieu");
    arm();
    drv(2'b00, 1'b0, 1'b0);
    step();
    drv(2'b00, 1'b1, 1'b1);
    step();
    expectCommit(2'b11, "R7 late retry");
  endtask

  task automatic tPriority();
    arm();
    drv(2'b00, 1'b1, 1'b1);
    step();
    expectCommit(2'b11, "R8 all at once");
    arm();
    drv(2'b00, 1'b1, 1'b0);
    step();
    expectCommit(2'b10, "R8 berr over ack");
  endtask

  task automatic tLateHalt();
    arm();
    drv(2'b00, 1'b0, 1'b0);
    step();
    drv(2'b00, 1'b0, 1'b1);
    step();
    expectCommit(2'b00, "R9 late halt ignored");
  endtask

  task automatic tIgnoreIdle();
    drv(2'b00, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step();
      check({1'b0, termDone}, 2'b00, "R11 idle done");
      check(termResult, 2'b00, "R11 idle result");
    end
    idleBus();
  endtask

  task automatic tLongWait();
    arm();
    drv(2'b11, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      step();
      check({1'b0, termDone}, 2'b00, "R12 still waiting");
    end
    drv(2'b00, 1'b0, 1'b0);
    step();
    step();
    expectCommit(2'b00, "R12 ends on ack");
  endtask

  task automatic tMidReset();
    arm();
    drv(2'b00, 1'b0, 1'b0);
    step();
    rst = 1'b1;
    step();
    check({1'b0, termDone}, 2'b00, "R1 reset mid cycle");
    check(termResult, 2'b00, "R1 reset clears result");
    rst = 1'b0;
    drv(2'b00, 1'b1, 1'b1);
    step();
    step();
    check({1'b0, termDone}, 2'b00, "R11 no commit after reset");
    idleBus();
  endtask

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step();
    tReset();
    tNormal(2'b00, "R3 normal");
    tNormal(2'b10, "R2 ack bit0");
    tNormal(2'b01, "R2 ack bit1");
    tHaltEarly();
    tBerrEarly();
    tBerrLate();
    tRetry();
    tPriority();
    tLateHalt();
    tIgnoreIdle();
    tLongWait();
    tMidReset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule